// File: doc/BRIEF.md
# I2C SCL multi-speed timing generator

This block produces the SCL waveform for an I2C controller. Software loads a high-phase count and a low-phase count, both in core clock cycles, for each speed class, plus an SDA hold count and a speed field. The speed field picks the active count pair. Standard mode has its own pair. Fast and fast-plus share one pair, and software tells them apart only by the values it writes. High speed has a third pair. A build-time capability parameter says whether high speed exists. Where it does not, a high-speed selection runs on the fast pair.

The byte engine holds `run` high while it wants bus clock periods. Each period begins with a low phase, in which SCL is driven low. A strobe marks the point in that phase where SDA may change. SCL is then released and the block waits until the line is seen high, so a target can stretch the clock. The high phase follows. All registers accept writes only while `enable` is low.

The sequencer has four states:
- `PH_IDLE`: SCL is released. The state moves to `PH_LOW` when `enable` and `run` are both high.
- `PH_LOW`: SCL is driven low. The state moves to `PH_WAIT` when the low count is reached.
- `PH_WAIT`: SCL is released. The state moves to `PH_HIGH` once `scl_in` is seen high.
- `PH_HIGH`: SCL is high. When the high count is reached, the state moves to `PH_LOW` if `run` is still high, and to `PH_IDLE` otherwise.

From any state other than `PH_IDLE`, a low `enable` returns the sequencer to `PH_IDLE`.

Top module: `scl_speed_timer`

## Requirements
- R1: After reset, `scl_drive_low`, `fall_tick`, `rise_tick` and `sda_tick` are all 0.
- R2: A clock period starts with `fall_tick` in the first cycle that `scl_drive_low` is 1. `scl_drive_low` then stays 1 for exactly the low count of the selected pair. A count of 0 acts as 1.
- R3: `rise_tick` is 1 in the first cycle of the high phase. The next `fall_tick` comes exactly the high count of cycles later, with a count of 0 acting as 1.
- R4: The register address map is: 0 speed field (bits 1:0), 1 standard high, 2 standard low, 3 fast high, 4 fast low, 5 high-speed high, 6 high-speed low, 7 SDA hold. Speed value 2 selects the fast pair, which also serves fast-plus. Value 3 selects the high-speed pair. Values 0 and 1 select the standard pair.
- R5: `sda_tick` is 1 when the low phase has run for the hold count of cycles after the `fall_tick` cycle. It stays 0 for that period if the hold count is not less than the effective low count.
- R6: After the low phase, SCL stays released and `rise_tick` is withheld while `scl_in` is 0. `rise_tick` appears in the cycle after `scl_in` is first sampled 1.
- R7: Clock periods begin only when `enable` and `run` are both 1. With `run` low at the end of a high phase, the block idles with SCL released. A low `enable` releases SCL by the next cycle.
- R8: Register writes made while `enable` is 1 are ignored.
- R9: With `HS_SUPPORT` = 0, speed value 3 uses the fast pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| enable | input | 1 | Controller enable; blocks register writes while 1 |
| run | input | 1 | Byte engine requests further clock periods |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_tick | output | 1 | First cycle of a low phase |
| rise_tick | output | 1 | First cycle of a high phase |
| sda_tick | output | 1 | SDA change point within the low phase |

## Verification
The bench measures each period's low length, its SDA-tick offset and its high length, and compares them with a model of the written registers. Two copies of the block run side by side, one built with high-speed support and one without. A design that ignored the capability parameter would run the high-speed counts on the second copy. A design that mapped speed 0 away from the standard pair would produce the wrong lengths.

Zero counts must act as one cycle, and a hold count equal to the low count must suppress `sda_tick`. An off-by-one terminal compare would show up in the measured lengths, and a missing hold guard would put an extra strobe in the period.

The bench also checks three behaviours at the ports:
- It holds `scl_in` low during a high phase. A design that ignored stretching would emit `rise_tick` early.
- It writes new counts while the block is enabled. A design that accepted those writes would change the period.
- It drops `enable` in the middle of a low phase. A design that finished the phase first would keep SCL low too long.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;
    localparam int ADDR_W    = 3;
    localparam int NUM_PAIRS = 3;

    localparam logic [ADDR_W-1:0] ADDR_SPEED = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_HOLD  = 3'd7;

    typedef enum logic [1:0] {
        SEL_STD_ALT = 2'd0,
        SEL_STD     = 2'd1,
        SEL_FAST    = 2'd2,
        SEL_HIGH    = 2'd3
    } speed_sel_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_t;
endpackage

// File: rtl/scl_tmr_regs.sv
module scl_tmr_regs
    import scl_tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HS_SUPPORT = 1'b1,
    parameter int RST_COUNT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  hi_lim,
    output logic [CNT_W-1:0]  lo_lim,
    output logic [CNT_W-1:0]  hold_lim
);
    localparam logic [1:0] HIGH_PAIR = HS_SUPPORT ? 2'd2 : 2'd1;

    logic             wr_ok;
    speed_sel_t       speed_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hi_arr [NUM_PAIRS];
    logic [CNT_W-1:0] lo_arr [NUM_PAIRS];
    logic [1:0]       pair_idx;

    assign wr_ok = reg_we && !enable;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [CNT_W-1:0] hi_r;
        logic [CNT_W-1:0] lo_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_r <= CNT_W'(RST_COUNT);
                lo_r <= CNT_W'(RST_COUNT);
            end else if (wr_ok) begin
                if (reg_addr == ADDR_W'(2 * g + 1)) hi_r <= reg_wdata;
                if (reg_addr == ADDR_W'(2 * g + 2)) lo_r <= reg_wdata;
            end
        end
        assign hi_arr[g] = hi_r;
        assign lo_arr[g] = lo_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q <= SEL_STD;
            hold_q  <= CNT_W'(1);
        end else if (wr_ok) begin
            if (reg_addr == ADDR_SPEED) speed_q <= speed_sel_t'(reg_wdata[1:0]);
            if (reg_addr == ADDR_HOLD)  hold_q  <= reg_wdata;
        end
    end

    always_comb begin
        unique case (speed_q)
            SEL_FAST: pair_idx = 2'd1;
            SEL_HIGH: pair_idx = HIGH_PAIR;
            default:  pair_idx = 2'd0;
        endcase
    end

    always_comb begin
        unique case (pair_idx)
            2'd1:    begin hi_lim = hi_arr[1]; lo_lim = lo_arr[1]; end
            2'd2:    begin hi_lim = hi_arr[2]; lo_lim = lo_arr[2]; end
            default: begin hi_lim = hi_arr[0]; lo_lim = lo_arr[0]; end
        endcase
    end

    assign hold_lim = hold_q;
endmodule

// File: rtl/scl_tmr_phase.sv
module scl_tmr_phase
    import scl_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hi_lim,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hold_lim,
    output logic             scl_drive_low,
    output logic             fall_tick,
    output logic             rise_tick,
    output logic             sda_tick
);
    localparam int EXT_W = CNT_W + 1;

    phase_t           state_q;
    phase_t           state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_next;
    logic             lo_done;
    logic             hi_done;

    assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);
    assign lo_done  = cnt_next >= {1'b0, lo_lim};
    assign hi_done  = cnt_next >= {1'b0, hi_lim};

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (enable && run) state_d = PH_LOW;
            PH_LOW: begin
                if (!enable)      state_d = PH_IDLE;
                else if (lo_done) state_d = PH_WAIT;
            end
            PH_WAIT: begin
                if (!enable)     state_d = PH_IDLE;
                else if (scl_in) state_d = PH_HIGH;
            end
            PH_HIGH: begin
                if (!enable)      state_d = PH_IDLE;
                else if (hi_done) state_d = run ? PH_LOW : PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_next[CNT_W-1:0];
        end
    end

    // outputs
    always_comb begin
        scl_drive_low = 1'b0;
        fall_tick     = 1'b0;
        rise_tick     = 1'b0;
        sda_tick      = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                scl_drive_low = 1'b1;
                fall_tick     = (cnt_q == '0);
                sda_tick      = (cnt_q == hold_lim);
            end
            PH_HIGH: rise_tick = (cnt_q == '0);
            default: ;
        endcase
    end
endmodule

// File: rtl/scl_speed_timer.sv
module scl_speed_timer
    import scl_tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HS_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             enable,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             fall_tick,
    output logic             rise_tick,
    output logic             sda_tick
);
    logic [CNT_W-1:0] hi_lim;
    logic [CNT_W-1:0] lo_lim;
    logic [CNT_W-1:0] hold_lim;

    scl_tmr_regs #(.CNT_W(CNT_W), .HS_SUPPORT(HS_SUPPORT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .hold_lim  (hold_lim)
    );

    scl_tmr_phase #(.CNT_W(CNT_W)) u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .run           (run),
        .scl_in        (scl_in),
        .hi_lim        (hi_lim),
        .lo_lim        (lo_lim),
        .hold_lim      (hold_lim),
        .scl_drive_low (scl_drive_low),
        .fall_tick     (fall_tick),
        .rise_tick     (rise_tick),
        .sda_tick      (sda_tick)
    );
endmodule

// File: rtl/scl_tmr_chk.sv
module scl_tmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             fall_tick,
    input logic             rise_tick,
    input logic             sda_tick,
    input logic [CNT_W-1:0] hi_lim,
    input logic [CNT_W-1:0] lo_lim,
    input logic [CNT_W-1:0] hold_lim
);
    p_low_opens_with_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> fall_tick);

    p_sda_inside_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tick |-> scl_drive_low);

    p_rise_after_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> $past(scl_in));

    p_release_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low);

    p_regs_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(hi_lim) && $stable(lo_lim) && $stable(hold_lim)));
endmodule

bind scl_speed_timer scl_tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .fall_tick     (fall_tick),
    .rise_tick     (rise_tick),
    .sda_tick      (sda_tick),
    .hi_lim        (hi_lim),
    .lo_lim        (lo_lim),
    .hold_lim      (hold_lim)
);

// File: tb/sim_scl_mon.sv
module sim_scl_mon (
    input logic clk,
    input logic drive_low,
    input logic fall_tick,
    input logic rise_tick,
    input logic sda_tick
);
    int    checks = 0;
    int    errors = 0;
    int    q_lo[$];
    int    q_sda[$];
    int    q_hi[$];
    string q_tag[$];
    bit    pend = 0;
    bit    in_hi = 0;
    int    lo_m = 0;
    int    sda_m = -1;
    int    hi_m = 0;

    task automatic push(input int lo, input int sda, input int hi, input string tag);
        q_lo.push_back(lo);
        q_sda.push_back(sda);
        q_hi.push_back(hi);
        q_tag.push_back(tag);
    endtask

    task automatic cmp(input string what, input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic fin(input bit with_hi);
        if (q_lo.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R7 unexpected clock period actual 1 expected 0");
        end else begin
            int    e_lo;
            int    e_sda;
            int    e_hi;
            string t;
            e_lo  = q_lo.pop_front();
            e_sda = q_sda.pop_front();
            e_hi  = q_hi.pop_front();
            t     = q_tag.pop_front();
            cmp("low length", lo_m, e_lo, t);
            cmp("sda offset", sda_m, e_sda, t);
            if (with_hi) cmp("high length", hi_m, e_hi, t);
        end
    endtask

    task automatic flush();
        if (pend) fin(1'b0);
        pend = 0;
        checks++;
        if (q_lo.size() != 0) begin
            errors++;
            $display("FAIL R7 missing clock periods actual %0d expected 0", q_lo.size());
            q_lo.delete(); q_sda.delete(); q_hi.delete(); q_tag.delete();
        end
    endtask

    task automatic abandon();
        pend = 0;
        q_lo.delete(); q_sda.delete(); q_hi.delete(); q_tag.delete();
    endtask

    always @(negedge clk) begin
        if (fall_tick) begin
            if (pend) fin(1'b1);
            pend  = 1;
            lo_m  = 0;
            sda_m = -1;
            hi_m  = 0;
            in_hi = 0;
        end
        if (pend) begin
            if (sda_tick) sda_m = lo_m;
            if (drive_low) lo_m++;
            if (rise_tick) in_hi = 1;
            if (in_hi) hi_m++;
        end
    end
endmodule

// File: tb/sim_scl_speed_timer.sv
module sim_scl_speed_timer;
    localparam int CNT_W = 16;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             reg_we = 0;
    logic [2:0]       reg_addr = '0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic             enable = 0;
    logic             run0 = 0;
    logic             run1 = 0;
    logic             stretch = 0;
    logic             drv0, fall0, rise0, sda0;
    logic             drv1, fall1, rise1, sda1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int sh_hi[3];
    int sh_lo[3];
    int sh_hold;
    int sh_spd;

    always #2 clk = ~clk;

    scl_speed_timer #(.CNT_W(CNT_W), .HS_SUPPORT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .enable(enable), .run(run0),
        .scl_in(!drv0 && !stretch), .scl_drive_low(drv0), .fall_tick(fall0),
        .rise_tick(rise0), .sda_tick(sda0)
    );

    scl_speed_timer #(.CNT_W(CNT_W), .HS_SUPPORT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .enable(enable), .run(run1),
        .scl_in(!drv1 && !stretch), .scl_drive_low(drv1), .fall_tick(fall1),
        .rise_tick(rise1), .sda_tick(sda1)
    );

    sim_scl_mon m0 (.clk(clk), .drive_low(drv0), .fall_tick(fall0), .rise_tick(rise0), .sda_tick(sda0));
    sim_scl_mon m1 (.clk(clk), .drive_low(drv1), .fall_tick(fall1), .rise_tick(rise1), .sda_tick(sda1));

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks + m0.checks + m1.checks,
                 errors + m0.errors + m1.errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected 0", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // register write with a bench-side model (R4 map, R8 ignore while enabled)
    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_we    = 1;
        reg_addr  = 3'(addr);
        reg_wdata = CNT_W'(data);
        if (!enable) begin
            if (addr == 0) sh_spd = data & 3;
            else if (addr == 7) sh_hold = data;
            else if (addr % 2 == 1) sh_hi[(addr - 1) / 2] = data;
            else sh_lo[(addr - 2) / 2] = data;
        end
        @(negedge clk);
        reg_we = 0;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int pair_of(input int spd, input bit hs);
        if (spd == 2) return 1;
        if (spd == 3) return hs ? 2 : 1;
        return 0;
    endfunction

    task automatic expect_periods(input int n, input string tag);
        for (int k = 0; k < 2; k++) begin
            int p;
            int lo;
            int hi;
            int sd;
            p  = pair_of(sh_spd, k == 0);
            lo = eff(sh_lo[p]);
            hi = eff(sh_hi[p]);
            sd = (sh_hold < lo) ? sh_hold : -1;
            for (int i = 0; i < n; i++) begin
                if (k == 0) m0.push(lo, sd, hi, tag);
                else        m1.push(lo, sd, hi, tag);
            end
        end
    endtask

    task automatic wait_rises(input bit which, input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (which ? rise1 : rise0) seen++;
        end
        if (which) run1 = 0;
        else       run0 = 0;
    endtask

    task automatic burst(input int n, input string tag);
        expect_periods(n, tag);
        @(negedge clk);
        enable = 1;
        run0   = 1;
        run1   = 1;
        fork
            wait_rises(1'b0, n);
            wait_rises(1'b1, n);
        join
        repeat (40) @(negedge clk);
        m0.flush();
        m1.flush();
        enable = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 drive_low after reset", int'(drv0), 0);
        chk("R1 ticks after reset", int'({fall0, rise0, sda0}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 drive_low idle", int'(drv0 | drv1), 0);

        // R2 R3 R4 R5: standard pair
        wr(1, 5); wr(2, 6); wr(3, 3); wr(4, 4); wr(5, 2); wr(6, 2);
        wr(7, 2); wr(0, 1);
        burst(3, "R2 R3 R4 R5 standard");

        // R4 fast pair (fast-plus shares it)
        wr(0, 2); wr(7, 1);
        burst(3, "R4 fast");

        // R2 R3 zero counts act as one, speed 0 aliases standard, hold 0
        wr(1, 0); wr(2, 0); wr(7, 0); wr(0, 0);
        burst(2, "R2 R3 zero counts");

        // R9: high speed select; u1 has no high speed and falls back to fast
        // R5 boundary: hold equal to the high-speed low count gives no sda tick
        wr(0, 3); wr(7, 2);
        burst(3, "R9 R5 high speed");

        // R8: writes while enabled are ignored; R7 no periods without run
        wr(0, 1); wr(1, 4); wr(2, 7); wr(7, 2);
        @(negedge clk);
        enable = 1;
        wr(2, 20); wr(0, 2); wr(7, 5);
        repeat (5) @(negedge clk);
        chk("R7 released with run low", int'(drv0 | drv1), 0);
        burst(2, "R8 ignored writes");

        // R6 clock stretching
        stretch = 1;
        expect_periods(2, "R6 stretch periods");
        @(negedge clk);
        enable = 1; run0 = 1; run1 = 1;
        do @(negedge clk); while (!drv0);
        do @(negedge clk); while (drv0);
        chk("R6 no rise while held low", int'(rise0), 0);
        repeat (4) begin
            @(negedge clk);
            chk("R6 no rise while held low", int'(rise0 | drv0), 0);
        end
        stretch = 0;
        @(negedge clk);
        chk("R6 rise after line high", int'(rise0), 1);
        fork
            wait_rises(1'b0, 1);
            wait_rises(1'b1, 1);
        join
        repeat (40) @(negedge clk);
        m0.flush();
        m1.flush();
        enable = 0;

        // R7 enable dropped during a low phase
        wr(2, 30);
        @(negedge clk);
        enable = 1; run0 = 1; run1 = 1;
        do @(negedge clk); while (!fall0);
        repeat (2) @(negedge clk);
        chk("R7 still low mid phase", int'(drv0), 1);
        enable = 0;
        @(negedge clk);
        chk("R7 released after disable", int'(drv0), 0);
        chk("R7 released after disable u1", int'(drv1), 0);
        m0.abandon();
        m1.abandon();
        run0 = 0; run1 = 0;
        repeat (5) @(negedge clk);
        chk("R7 stays idle", int'(drv0 | drv1 | fall0 | fall1), 0);

        summary();
        $finish;
    end
endmodule